// File: doc/BRIEF.md
# Random Tie-Breaking Argmax Selector

This block takes a vector of `N` signed scores, one per candidate, and returns the index of one candidate that holds the largest score. It is meant for local-search engines that must pick one move out of many. Every candidate that reaches the best score is recorded in a bitmask of tied holders. One of those bits is then picked with a free-running 16-bit LFSR. This spreads the choice over all tied candidates, so the lowest or highest index is not always favoured.

The comparison starts from a running maximum of -1. A candidate therefore counts only when its score is at least -1. If no candidate reaches -1, the result is the invalid index -1 (all ones). A parameter selects one of two structures. The tree form finds the maximum with a balanced comparator tree and answers one cycle after the input. The sequential form captures the vector and examines one candidate per clock, which saves comparators at the cost of latency.

Top module: `argmax_tiebreak`

## Requirements
- R1: While reset is low, and after it is released, `sel_valid_o` is 0 and `sel_index_o` is all ones (-1). It stays that way until the first result.
- R2: When exactly one candidate holds the maximum score (with that maximum at least -1), the result is that candidate's index, whatever the LFSR value is.
- R3: When k > 1 candidates tie at the maximum, the result is found as follows. Take the tie mask, in which bit i stands for candidate i. The result is the position of its (r mod k)-th set bit, counting from 0 upward from bit 0. Here r is the 16-bit LFSR value during the cycle in which the decision is registered.
- R4: The running maximum starts at -1. A score of exactly -1 can win. If every score is below -1, the result index is -1 (all ones).
- R5: The LFSR is loaded from `seed_i` while reset is low, with a seed of 0 replaced by 1. It then advances on every clock as s <= {s[14:0], s[15]^s[13]^s[12]^s[10]}.
- R6: Tree form: a vector presented with `scores_valid_i` high at a clock edge yields `sel_valid_o` high during the cycle after that edge only, with its index. Back-to-back vectors give back-to-back results.
- R7: Sequential form: a vector is accepted at an edge while the block is idle. The block then examines candidates 0 to N-1, one per edge. `sel_valid_o` is a one-cycle pulse that rises N+1 edges after the accepting edge.
- R8: Sequential form: `scores_valid_i` is ignored while a vector is being examined. No extra result is produced, and the pending result is unchanged.
- R9: `sel_index_o` holds its last value while `sel_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; loads the LFSR seed |
| seed_i | input | 16 | LFSR seed, sampled while reset is low |
| scores_valid_i | input | 1 | Score vector present |
| scores_i | input | N*W | Candidate i score in bits [i*W +: W], two's complement |
| sel_valid_o | output | 1 | Result strobe |
| sel_index_o | output | $clog2(N)+1 | Chosen index, signed; -1 when no candidate qualifies |

## Verification
Two functions can meet in the same cycle. The first is the LFSR step. The second is the registering of a decision, which samples the LFSR value of that cycle. To provoke this, the bench holds the tree form's valid input high over many cycles with an all-tied vector. This forces a decision on every edge while the LFSR keeps moving. Each result is judged against a bench model of the LFSR: it is read in the cycle before the edge, reduced mod k, and mapped onto the mask. In the sequential form, a new valid input that arrives while a scan is in flight collides with the running scan. The bench judges that case by counting result pulses and comparing the one index that appears with the first vector's answer.

// File: rtl/argmax_pkg.sv
package argmax_pkg;
  localparam int LFSR_W = 16;

  function automatic logic [LFSR_W-1:0] lfsr_step(logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
endpackage

// File: rtl/argmax_lfsr.sv
module argmax_lfsr
  import argmax_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LFSR_W-1:0] seed_i,
  output logic [LFSR_W-1:0] rnd_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rnd_o <= (seed_i == '0) ? LFSR_W'(1) : seed_i;
    else         rnd_o <= lfsr_step(rnd_o);
  end
endmodule

// File: rtl/argmax_mask_tree.sv
module argmax_mask_tree #(
  parameter int N = 8,
  parameter int W = 8
) (
  input  logic [N*W-1:0] scores_i,
  output logic [N-1:0]   mask_o
);
  localparam int LV = (N > 1) ? $clog2(N) : 1;
  localparam int P  = 1 << LV;
  localparam logic signed [W-1:0] NEG1 = '1;
  localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic signed [W-1:0] lvl [LV+1][P];

  for (genvar j = 0; j < P; j++) begin : g_leaf
    if (j < N) begin : g_real
      assign lvl[0][j] = scores_i[j*W +: W];
    end else begin : g_pad
      assign lvl[0][j] = MINV;
    end
  end

  for (genvar l = 0; l < LV; l++) begin : g_lvl
    for (genvar j = 0; j < (P >> (l + 1)); j++) begin : g_node
      assign lvl[l+1][j] = (lvl[l][2*j] >= lvl[l][2*j+1]) ? lvl[l][2*j] : lvl[l][2*j+1];
    end
    for (genvar j = (P >> (l + 1)); j < P; j++) begin : g_unused
      assign lvl[l+1][j] = MINV;
    end
  end

  logic signed [W-1:0] top_max;
  assign top_max = lvl[LV][0];

  for (genvar i = 0; i < N; i++) begin : g_mask
    logic signed [W-1:0] s;
    assign s = scores_i[i*W +: W];
    assign mask_o[i] = (s == top_max) && (top_max >= NEG1);
  end
endmodule

// File: rtl/argmax_mask_seq.sv
module argmax_mask_seq #(
  parameter int N = 8,
  parameter int W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           valid_i,
  input  logic [N*W-1:0] scores_i,
  output logic [N-1:0]   mask_o,
  output logic           done_o
);
  localparam int CNTW = (N > 1) ? $clog2(N) : 1;
  localparam logic signed [W-1:0] NEG1 = '1;

  logic [N*W-1:0]      cap_q;
  logic signed [W-1:0] run_max_q;
  logic [CNTW-1:0]     cnt_q;
  logic                busy_q;
  logic signed [W-1:0] cur;

  assign cur = cap_q[cnt_q*W +: W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q     <= '0;
      run_max_q <= NEG1;
      cnt_q     <= '0;
      busy_q    <= 1'b0;
      done_o    <= 1'b0;
      mask_o    <= '0;
    end else if (valid_i && !busy_q && !done_o) begin
      cap_q     <= scores_i;
      run_max_q <= NEG1;
      mask_o    <= '0;
      cnt_q     <= '0;
      busy_q    <= 1'b1;
    end else if (busy_q) begin
      if (cur > run_max_q) begin
        run_max_q     <= cur;
        mask_o        <= '0;
        mask_o[cnt_q] <= 1'b1;
      end else if (cur == run_max_q) begin
        mask_o[cnt_q] <= 1'b1;
      end
      if (cnt_q == CNTW'(N - 1)) begin
        busy_q <= 1'b0;
        done_o <= 1'b1;
      end
      cnt_q <= cnt_q + 1'b1;
    end else begin
      done_o <= 1'b0;
    end
  end
endmodule

// File: rtl/argmax_pick.sv
module argmax_pick
  import argmax_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = 4
) (
  input  logic [N-1:0]      mask_i,
  input  logic [LFSR_W-1:0] rnd_i,
  output logic [IW-1:0]     index_o
);
  localparam int CW = $clog2(N + 1);

  logic [CW-1:0]     k;
  logic [LFSR_W-1:0] rem;
  logic [CW-1:0]     cnt;

  assign k = CW'($countones(mask_i));

  always_comb begin
    rem     = (k == '0) ? '0 : rnd_i % {{(LFSR_W-CW){1'b0}}, k};
    cnt     = '0;
    index_o = '1;
    for (int i = 0; i < N; i++) begin
      if (mask_i[i]) begin
        if ({{(LFSR_W-CW){1'b0}}, cnt} == rem) index_o = IW'(i);
        cnt = CW'(cnt + 1'b1);
      end
    end
  end
endmodule

// File: rtl/argmax_tiebreak.sv
module argmax_tiebreak
  import argmax_pkg::*;
#(
  parameter int N        = 8,
  parameter int W        = 8,
  parameter bit SEQ_MODE = 1'b0,
  localparam int IW      = $clog2(N) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LFSR_W-1:0] seed_i,
  input  logic              scores_valid_i,
  input  logic [N*W-1:0]    scores_i,
  output logic              sel_valid_o,
  output logic [IW-1:0]     sel_index_o
);
  logic [LFSR_W-1:0] lfsr_q;
  logic [N-1:0]      mask_q;
  logic              go_q;
  logic [IW-1:0]     pick_idx;

  argmax_lfsr u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .seed_i (seed_i),
    .rnd_o  (lfsr_q)
  );

  if (SEQ_MODE) begin : g_seq
    argmax_mask_seq #(.N(N), .W(W)) u_mask (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .valid_i  (scores_valid_i),
      .scores_i (scores_i),
      .mask_o   (mask_q),
      .done_o   (go_q)
    );
  end else begin : g_tree
    argmax_mask_tree #(.N(N), .W(W)) u_mask (
      .scores_i (scores_i),
      .mask_o   (mask_q)
    );
    assign go_q = scores_valid_i;
  end

  argmax_pick #(.N(N), .IW(IW)) u_pick (
    .mask_i  (mask_q),
    .rnd_i   (lfsr_q),
    .index_o (pick_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_valid_o <= 1'b0;
      sel_index_o <= '1;
    end else begin
      sel_valid_o <= go_q;
      if (go_q) sel_index_o <= pick_idx;
    end
  end
endmodule

// File: rtl/argmax_tiebreak_chk.sv
module argmax_tiebreak_chk #(
  parameter int N        = 8,
  parameter int W        = 8,
  parameter bit SEQ_MODE = 1'b0,
  parameter int IW       = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           scores_valid_i,
  input logic [N*W-1:0] scores_i,
  input logic           sel_valid_o,
  input logic [IW-1:0]  sel_index_o,
  input logic [15:0]    lfsr_q,
  input logic [N-1:0]   mask_q
);
  function automatic bit holds_max(logic [N*W-1:0] v, logic [IW-1:0] ix);
    logic signed [W-1:0] ref_s;
    logic signed [W-1:0] oth;
    ref_s = v[int'(ix[IW-2:0])*W +: W];
    for (int j = 0; j < N; j++) begin
      oth = v[j*W +: W];
      if (oth > ref_s) return 1'b0;
    end
    return 1'b1;
  endfunction

  p_lfsr_nonzero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != '0);

  p_index_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_valid_o |-> (sel_index_o == '1) || (int'(sel_index_o) < N));

  p_single_holder_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_valid_o && $countones($past(mask_q)) == 1) |->
      ($past(mask_q) == (N'(1) << sel_index_o[IW-2:0])) && !sel_index_o[IW-1]);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_valid_o |-> $stable(sel_index_o));

  if (SEQ_MODE) begin : g_seq_chk
    p_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sel_valid_o |=> !sel_valid_o);
  end else begin : g_tree_chk
    p_latency_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      scores_valid_i |=> sel_valid_o);
    p_no_spurious_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !scores_valid_i |=> !sel_valid_o);
    p_is_max_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_valid_o && !sel_index_o[IW-1]) |-> holds_max($past(scores_i), sel_index_o));
  end
endmodule

bind argmax_tiebreak argmax_tiebreak_chk #(.N(N), .W(W), .SEQ_MODE(SEQ_MODE), .IW(IW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .scores_valid_i (scores_valid_i),
  .scores_i       (scores_i),
  .sel_valid_o    (sel_valid_o),
  .sel_index_o    (sel_index_o),
  .lfsr_q         (lfsr_q),
  .mask_q         (mask_q)
);

// File: tb/argmax_tiebreak_tb_top.sv
module argmax_tiebreak_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int W  = 8;
  localparam int IW = $clog2(N) + 1;
  localparam int NV = 8;

  localparam logic [N*W-1:0] VEC [NV] = '{
    64'h0503027F0100FF10,  // unique max at 4
    64'h0000000000000000,  // eight-way tie
    64'h0020000000002000,  // tie at 1 and 6
    64'hFBFBFBFBFBFBFBFB,  // all below -1
    64'h80808080FF8080FF,  // -1 tie at 0 and 3
    64'h7F7E7E7E7E7E7E7E,  // unique at 7
    64'h4000400000400000,  // tie at 2,5,7
    64'h8080FE8080808080   // best is -2: none
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] seed = 16'hACE1;
  logic vld_t = 1'b0, vld_s = 1'b0;
  logic [N*W-1:0] scores = '0;
  logic sv_t, sv_s;
  logic [IW-1:0] si_t, si_s;
  logic [15:0] m_lfsr;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // bench model of the LFSR taken from R5
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_lfsr <= (seed == 16'd0) ? 16'd1 : seed;
    else        m_lfsr <= {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
  end

  argmax_tiebreak #(.N(N), .W(W), .SEQ_MODE(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .seed_i(seed), .scores_valid_i(vld_t),
    .scores_i(scores), .sel_valid_o(sv_t), .sel_index_o(si_t));

  argmax_tiebreak #(.N(N), .W(W), .SEQ_MODE(1'b1)) dut_seq_i (
    .clk_i(clk), .rst_ni(rst_n), .seed_i(seed), .scores_valid_i(vld_s),
    .scores_i(scores), .sel_valid_o(sv_s), .sel_index_o(si_s));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [IW-1:0] exp_pick(logic [N*W-1:0] v, logic [15:0] r);
    logic signed [W-1:0] mx, s;
    logic [N-1:0] m;
    int k, sel, c;
    mx = -1; m = '0;
    for (int i = 0; i < N; i++) begin
      s = v[i*W +: W];
      if (s > mx) begin mx = s; m = '0; m[i] = 1'b1; end
      else if (s == mx) m[i] = 1'b1;
    end
    k = $countones(m);
    if (k == 0) return '1;
    sel = int'(r % 16'(k));
    c = 0;
    for (int i = 0; i < N; i++) if (m[i]) begin
      if (c == sel) return IW'(i);
      c++;
    end
    return '1;
  endfunction

  task automatic do_reset(logic [15:0] sd);
    @(negedge clk);
    rst_n = 1'b0; seed = sd; vld_t = 0; vld_s = 0;
    @(negedge clk);
    chk("R1 valid in reset", 32'(sv_t), 0);
    chk("R1 index in reset", 32'(si_s), 32'(4'hF));
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 tree valid after reset", 32'(sv_t), 0);
    chk("R1 seq index after reset", 32'(si_s), 32'(4'hF));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] r;
    logic [IW-1:0] e;
    int pulses;
    do_reset(16'hACE1);

    // table walk: both forms on each vector (R2, R3, R4, R6, R7)
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      scores = VEC[v]; vld_t = 1; vld_s = 1;
      r = m_lfsr;
      @(negedge clk);
      vld_t = 0; vld_s = 0;
      chk("R6 tree valid", 32'(sv_t), 1);
      chk("R2/R3/R4 tree index", 32'(si_t), 32'(exp_pick(VEC[v], r)));
      repeat (N) @(negedge clk);
      chk("R6 tree pulse ended", 32'(sv_t), 0);
      chk("R7 seq not early", 32'(sv_s), 0);
      r = m_lfsr;
      @(negedge clk);
      chk("R7 seq valid", 32'(sv_s), 1);
      chk("R2/R3/R4 seq index", 32'(si_s), 32'(exp_pick(VEC[v], r)));
      @(negedge clk);
      chk("R7 seq single pulse", 32'(sv_s), 0);
    end

    // R9: outputs hold while inputs change without valid
    e = si_s;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      scores = VEC[c];
      chk("R9 seq hold", 32'(si_s), 32'(e));
    end

    // R8: second valid during scan is ignored
    @(negedge clk);
    scores = VEC[0]; vld_s = 1;
    @(negedge clk);
    vld_s = 0;
    repeat (2) @(negedge clk);
    scores = VEC[5]; vld_s = 1;
    @(negedge clk);
    vld_s = 0;
    pulses = 0;
    for (int c = 0; c < 3 * N; c++) begin
      @(negedge clk);
      if (sv_s) begin
        pulses++;
        chk("R8 first vector result kept", 32'(si_s), 4);
      end
    end
    chk("R8 one result only", 32'(pulses), 1);

    // R5/R6: back-to-back eight-way ties follow the LFSR every cycle
    @(negedge clk);
    scores = '0; vld_t = 1;
    r = m_lfsr;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      chk("R6 back-to-back valid", 32'(sv_t), 1);
      chk("R5 lfsr-driven pick", 32'(si_t), 32'(r[2:0]));
      r = m_lfsr;
    end
    vld_t = 0;

    // R5: zero seed behaves as seed 1
    do_reset(16'h0000);
    @(negedge clk);
    scores = '0; vld_t = 1;
    r = m_lfsr;
    @(negedge clk);
    vld_t = 0;
    chk("R5 zero seed pick", 32'(si_t), 32'(r[2:0]));
    chk("R5 zero seed model", 32'(r == 16'd0), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule